// File: doc/BRIEF.md
# Packet Page Allocator with Queues

This block manages the packet memory of a small Ethernet controller. The memory is split into a fixed number of pages, four by default. The block keeps one bit per page to record which pages are in use, and it hands out pages on request. It also holds three short queues of page numbers. The receive queue lists received frames that the host has not yet handled. The transmit queue lists pages waiting to go out. The completion queue lists pages that have been sent but not yet returned by the host. The packet bytes themselves live elsewhere.

The host drives the block with 3-bit commands carried in the top bits of a written byte. It can also write a packet-number register, an interrupt mask and an interrupt acknowledge. The receive side asks for a page through a one-cycle request and gets a response one cycle later. While transmit is enabled, the block takes one page per cycle from the head of the transmit queue. For each such page it emits a one-cycle strobe and then either frees the page or records it in the completion queue. A single masked interrupt line summarises the status bits.

At most one event that touches the allocator is served per cycle. Host commands come first, then receive requests, then transmit steps.

Top module: `pkt_page_mmu`

## Requirements
- R1: After synchronous reset, the outputs have these values: int_status is 0x04, int_mask is 0, irq is 0, alloc_result is 0x80, used_pages is 0, rx_head and done_head are 0x80, mem_pages is NUM_PAGES, and tx_strobe is 0.
- R2: When cmd_wr is high, the command code is cmd_byte[7:5] and cmd_byte[4:0] are ignored. Code 0 changes nothing.
- R3: Code 1 (allocate) takes the lowest-numbered free page. In the cycle after the write, alloc_result holds that page number, used_pages has risen by one and status bit 3 (allocation done) is set.
- R4: If code 1 finds no free page, alloc_result becomes 0x80, status bit 3 is cleared and the request stays pending. The next page release (code 4, code 5 or auto-release) grants the freed page, sets alloc_result to it and sets bit 3.
- R5: irq is high exactly when int_status AND int_mask is non-zero. A mask write takes effect on irq in the next cycle.
- R6: An acknowledge write clears only the status bits that are set in both ack_in and 0xD6. If ack_in bit 1 is set, the acknowledge also removes one entry from the completion queue.
- R7: Status bit 2 is set in every cycle the transmit queue is empty. Status bit 1 is set in every cycle the completion queue is non-empty. Both are set again after an acknowledge while their condition holds.
- R8: A receive request takes the lowest free page, pushes it to the receive queue, sets status bit 0 and reports the page on rx_resp_page with rx_resp_vld. The request is refused, with page 0x80 reported and status bit 4 set, if all pages are in use, if the receive queue is full, or if cmd_wr is high in the same cycle.
- R9: Code 3 removes the head of the receive queue. Code 4 also frees the head's page. After either one, status bit 0 is set if entries remain and cleared if the queue is empty.
- R10: While tx_en is high and the transmit queue is not empty, one page per cycle leaves the queue in FIFO order and appears on tx_page with a one-cycle tx_strobe. If auto_rel is high the page is freed. Otherwise it is pushed to the completion queue, and the push is dropped if that queue is full.
- R11: Code 5 frees the page named by the low bits of the packet-number register. Code 6 pushes that page number to the transmit queue, and a push to a full transmit queue is ignored.
- R12: Code 2 clears the page bitmask, all three queues and the pending allocation, and sets alloc_result to 0x80. Code 7 empties only the transmit and completion queues.
- R13: rx_head and done_head show 0x80 when their queue is empty and the head page number otherwise. used_pages is the number of pages in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte; code in bits 7:5 |
| pnum_wr | input | 1 | Packet-number register write strobe |
| pnum_in | input | 8 | New packet-number value |
| ack_wr | input | 1 | Interrupt acknowledge write strobe |
| ack_in | input | 8 | Acknowledge bit pattern |
| mask_wr | input | 1 | Interrupt mask write strobe |
| mask_in | input | 8 | New interrupt mask |
| rx_req | input | 1 | Receive-side page request |
| tx_en | input | 1 | Transmit enable |
| auto_rel | input | 1 | Free transmitted pages instead of queuing completion |
| rx_resp_vld | output | 1 | Response to the previous cycle's receive request |
| rx_resp_page | output | 8 | Granted page, or 0x80 if refused |
| tx_strobe | output | 1 | One-cycle pulse per transmitted page |
| tx_page | output | 8 | Page number of the last transmitted page |
| irq | output | 1 | Masked interrupt |
| int_status | output | 8 | Interrupt status bits |
| int_mask | output | 8 | Interrupt mask register |
| pnum | output | 8 | Packet-number register |
| alloc_result | output | 8 | Last allocate result, 0x80 if failed or none |
| done_head | output | 8 | Completion queue head, 0x80 if empty |
| rx_head | output | 8 | Receive queue head, 0x80 if empty |
| mem_pages | output | 8 | Total number of pages |
| used_pages | output | 8 | Number of pages in use |

## Verification
Allocation is tested with sequential fills from empty. These fills are followed by releases in the middle of the page range, which tell lowest-free selection apart from round-robin or last-freed order. Allocating into a full memory and then releasing, either by command or by auto-release during transmit, separates a pending retry from a failure that is simply dropped. The receive path is driven to refusal in two ways: with every page in use, and with the queue full while a page is free. This shows which of the two limits the refusal obeys. A sweep over all 256 acknowledge patterns on a fixed status of 0x1F, and over all 256 mask values, checks every bit of the 0xD6 write mask, the completion-queue pop on bit 1, the re-setting of the derived bits, and the irq reduction.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam logic [7:0] NO_PAGE       = 8'h80;
  localparam logic [7:0] ACK_CLEARABLE = 8'hD6;

  localparam int IB_RX    = 0;
  localparam int IB_TX    = 1;
  localparam int IB_TXE   = 2;
  localparam int IB_ALLOC = 3;
  localparam int IB_OVRN  = 4;

  typedef enum logic [2:0] {
    CMD_NOP        = 3'd0,
    CMD_ALLOC      = 3'd1,
    CMD_RESET      = 3'd2,
    CMD_RXPOP      = 3'd3,
    CMD_RXPOP_FREE = 3'd4,
    CMD_FREE       = 3'd5,
    CMD_TXQ        = 3'd6,
    CMD_TXCLR      = 3'd7
  } mmu_cmd_e;
endpackage

// File: rtl/page_alloc.sv
module page_alloc #(
  parameter int N  = 4,
  parameter int PW = 2,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          rel,
  input  logic [PW-1:0] rel_idx,
  input  logic          alloc,
  output logic          alloc_ok,
  output logic [PW-1:0] alloc_idx,
  output logic [CW-1:0] used_cnt
);
  logic [N-1:0] bm_q, after_rel, bm_n;
  logic         any_free;

  // release is applied first, so a retry in the same cycle sees the freed page
  always_comb begin
    after_rel = bm_q;
    if (rel) after_rel[rel_idx] = 1'b0;
    any_free  = 1'b0;
    alloc_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!after_rel[i]) begin
        any_free  = 1'b1;
        alloc_idx = PW'(i);
      end
    end
    alloc_ok = alloc && any_free;
    bm_n = after_rel;
    if (alloc_ok) bm_n[alloc_idx] = 1'b1;
  end

  always_comb begin
    used_cnt = '0;
    for (int i = 0; i < N; i++) used_cnt = used_cnt + CW'(bm_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) bm_q <= '0;
    else            bm_q <= bm_n;
  end
endmodule

// File: rtl/page_queue.sv
module page_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          do_push, do_pop;

  assign do_push = push && (cnt != CW'(DEPTH));
  assign do_pop  = pop && (cnt != '0);
  assign head    = mem[rp_q];

  always_comb begin
    if (clr) cnt_nxt = '0;
    else     cnt_nxt = cnt + CW'(do_push) - CW'(do_pop);
  end

  // storage without reset so it maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp_q <= '0;
      rp_q <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/pkt_page_mmu.sv
module pkt_page_mmu
  import mmu_pkg::*;
#(
  parameter int NUM_PAGES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  input  logic       pnum_wr,
  input  logic [7:0] pnum_in,
  input  logic       ack_wr,
  input  logic [7:0] ack_in,
  input  logic       mask_wr,
  input  logic [7:0] mask_in,
  input  logic       rx_req,
  input  logic       tx_en,
  input  logic       auto_rel,
  output logic       rx_resp_vld,
  output logic [7:0] rx_resp_page,
  output logic       tx_strobe,
  output logic [7:0] tx_page,
  output logic       irq,
  output logic [7:0] int_status,
  output logic [7:0] int_mask,
  output logic [7:0] pnum,
  output logic [7:0] alloc_result,
  output logic [7:0] done_head,
  output logic [7:0] rx_head,
  output logic [7:0] mem_pages,
  output logic [7:0] used_pages
);
  localparam int PW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam int CW = $clog2(NUM_PAGES + 1);

  mmu_cmd_e      cmd;
  logic          unused_cmd_low;
  logic [PW-1:0] rx_hd, tx_hd, dn_hd, rel_idx, alloc_idx;
  logic [CW-1:0] rx_cnt, txq_cnt, done_cnt, rx_cnt_n, txq_cnt_n, done_cnt_n, used_cnt;
  logic          rx_empty, rx_full, tx_empty;
  logic          rx_take, tx_take, rel, retry, alloc_req, alloc_ok, a_clr, rx_push;
  logic          q_clr_tx;
  logic [7:0]    st_q, st_n, mask_q, mask_n, pnum_q, res_q, res_n;
  logic          pend_q, pend_n, irq_q;
  logic          rxv_q, txs_q;
  logic [7:0]    rxp_q, txp_q;

  assign cmd            = cmd_wr ? mmu_cmd_e'(cmd_byte[7:5]) : CMD_NOP;
  assign unused_cmd_low = ^cmd_byte[4:0];

  assign rx_empty = (rx_cnt == '0);
  assign rx_full  = (rx_cnt == CW'(NUM_PAGES));
  assign tx_empty = (txq_cnt == '0);

  // arbitration: host command, then receive request, then a transmit step
  assign rx_take = rx_req && !cmd_wr;
  assign tx_take = tx_en && !tx_empty && !cmd_wr && !rx_req;

  always_comb begin
    rel     = 1'b0;
    rel_idx = '0;
    case (cmd)
      CMD_RXPOP_FREE: if (!rx_empty) begin
        rel     = 1'b1;
        rel_idx = rx_hd;
      end
      CMD_FREE: begin
        rel     = 1'b1;
        rel_idx = pnum_q[PW-1:0];
      end
      default: ;
    endcase
    if (tx_take && auto_rel) begin
      rel     = 1'b1;
      rel_idx = tx_hd;
    end
  end

  assign retry     = rel && pend_q;
  assign alloc_req = (cmd == CMD_ALLOC) || retry || (rx_take && !rx_full);
  assign a_clr     = (cmd == CMD_RESET);
  assign rx_push   = rx_take && !rx_full && alloc_ok;
  assign q_clr_tx  = a_clr || (cmd == CMD_TXCLR);

  page_alloc #(.N(NUM_PAGES), .PW(PW), .CW(CW)) u_alloc (
    .clk(clk), .rst(rst), .clr(a_clr),
    .rel(rel), .rel_idx(rel_idx),
    .alloc(alloc_req), .alloc_ok(alloc_ok), .alloc_idx(alloc_idx),
    .used_cnt(used_cnt)
  );

  page_queue #(.DEPTH(NUM_PAGES), .W(PW), .CW(CW)) u_rxq (
    .clk(clk), .rst(rst), .clr(a_clr),
    .push(rx_push), .din(alloc_idx),
    .pop((cmd == CMD_RXPOP) || (cmd == CMD_RXPOP_FREE)),
    .head(rx_hd), .cnt(rx_cnt), .cnt_nxt(rx_cnt_n)
  );

  page_queue #(.DEPTH(NUM_PAGES), .W(PW), .CW(CW)) u_txq (
    .clk(clk), .rst(rst), .clr(q_clr_tx),
    .push(cmd == CMD_TXQ), .din(pnum_q[PW-1:0]),
    .pop(tx_take),
    .head(tx_hd), .cnt(txq_cnt), .cnt_nxt(txq_cnt_n)
  );

  page_queue #(.DEPTH(NUM_PAGES), .W(PW), .CW(CW)) u_doneq (
    .clk(clk), .rst(rst), .clr(q_clr_tx),
    .push(tx_take && !auto_rel), .din(tx_hd),
    .pop(ack_wr && ack_in[IB_TX]),
    .head(dn_hd), .cnt(done_cnt), .cnt_nxt(done_cnt_n)
  );

  always_comb begin
    st_n = st_q;
    if (ack_wr) st_n = st_n & ~(ack_in & ACK_CLEARABLE);
    if (cmd == CMD_ALLOC)      st_n[IB_ALLOC] = alloc_ok;
    else if (retry && alloc_ok) st_n[IB_ALLOC] = 1'b1;
    if (rx_push)               st_n[IB_RX]   = 1'b1;
    if (rx_req && !rx_push)    st_n[IB_OVRN] = 1'b1;
    if ((cmd == CMD_RXPOP) || (cmd == CMD_RXPOP_FREE))
      st_n[IB_RX] = (rx_cnt_n != '0);
    if (txq_cnt_n == '0)       st_n[IB_TXE] = 1'b1;
    if (done_cnt_n != '0)      st_n[IB_TX]  = 1'b1;
  end

  always_comb begin
    pend_n = pend_q;
    res_n  = res_q;
    if (cmd == CMD_ALLOC) begin
      pend_n = !alloc_ok;
      res_n  = alloc_ok ? 8'(alloc_idx) : NO_PAGE;
    end else if (retry) begin
      pend_n = !alloc_ok;
      if (alloc_ok) res_n = 8'(alloc_idx);
    end
    if (a_clr) begin
      pend_n = 1'b0;
      res_n  = NO_PAGE;
    end
  end

  assign mask_n = mask_wr ? mask_in : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= 8'h01 << IB_TXE;
      mask_q <= '0;
      pnum_q <= '0;
      res_q  <= NO_PAGE;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
      rxv_q  <= 1'b0;
      rxp_q  <= NO_PAGE;
      txs_q  <= 1'b0;
      txp_q  <= '0;
    end else begin
      st_q   <= st_n;
      mask_q <= mask_n;
      if (pnum_wr) pnum_q <= pnum_in;
      res_q  <= res_n;
      pend_q <= pend_n;
      irq_q  <= |(st_n & mask_n);
      rxv_q  <= rx_req;
      rxp_q  <= rx_push ? 8'(alloc_idx) : NO_PAGE;
      txs_q  <= tx_take;
      if (tx_take) txp_q <= 8'(tx_hd);
    end
  end

  assign rx_resp_vld  = rxv_q;
  assign rx_resp_page = rxp_q;
  assign tx_strobe    = txs_q;
  assign tx_page      = txp_q;
  assign irq          = irq_q;
  assign int_status   = st_q;
  assign int_mask     = mask_q;
  assign pnum         = pnum_q;
  assign alloc_result = res_q;
  assign done_head    = (done_cnt == '0) ? NO_PAGE : 8'(dn_hd);
  assign rx_head      = rx_empty ? NO_PAGE : 8'(rx_hd);
  assign mem_pages    = 8'(NUM_PAGES);
  assign used_pages   = 8'(used_cnt);
endmodule

// File: rtl/mmu_checker.sv
module mmu_checker #(
  parameter int NUM_PAGES = 4,
  parameter int CW        = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_wr,
  input logic [7:0]    cmd_byte,
  input logic          rx_req,
  input logic          rx_resp_vld,
  input logic          irq,
  input logic [7:0]    int_status,
  input logic [7:0]    int_mask,
  input logic [7:0]    alloc_result,
  input logic [7:0]    rx_head,
  input logic [7:0]    used_pages,
  input logic [CW-1:0] txq_cnt,
  input logic [CW-1:0] done_cnt,
  input logic [CW-1:0] rx_cnt
);
  p_irq_level_r5: assert property (@(posedge clk) disable iff (rst)
    irq == |(int_status & int_mask));

  p_txempty_set_r7: assert property (@(posedge clk) disable iff (rst)
    (txq_cnt == '0) |-> int_status[2]);

  p_txdone_set_r7: assert property (@(posedge clk) disable iff (rst)
    (done_cnt != '0) |-> int_status[1]);

  p_rcv_not_acked_r6: assert property (@(posedge clk) disable iff (rst)
    (int_status[0] && !(cmd_wr && (cmd_byte[7:5] == 3'd3 || cmd_byte[7:5] == 3'd4)))
    |=> int_status[0]);

  p_full_alloc_fails_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_byte[7:5] == 3'd1 && used_pages == 8'(NUM_PAGES))
    |=> (alloc_result == 8'h80 && !int_status[3]));

  p_rx_resp_r8: assert property (@(posedge clk) disable iff (rst)
    rx_req |=> rx_resp_vld);

  p_used_bound_r13: assert property (@(posedge clk) disable iff (rst)
    used_pages <= 8'(NUM_PAGES));

  p_rx_head_empty_r13: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt == '0) |-> (rx_head == 8'h80));
endmodule

bind pkt_page_mmu mmu_checker #(.NUM_PAGES(NUM_PAGES), .CW(CW)) u_mmu_checker (
  .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
  .rx_req(rx_req), .rx_resp_vld(rx_resp_vld), .irq(irq),
  .int_status(int_status), .int_mask(int_mask), .alloc_result(alloc_result),
  .rx_head(rx_head), .used_pages(used_pages),
  .txq_cnt(txq_cnt), .done_cnt(done_cnt), .rx_cnt(rx_cnt)
);

// File: tb/test_pkt_page_mmu.sv
`timescale 1ns/1ps
module test_pkt_page_mmu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_wr = 0, pnum_wr = 0, ack_wr = 0, mask_wr = 0;
  logic       rx_req = 0, tx_en = 0, auto_rel = 0;
  logic [7:0] cmd_byte = 0, pnum_in = 0, ack_in = 0, mask_in = 0;
  logic       rx_resp_vld, tx_strobe, irq;
  logic [7:0] rx_resp_page, tx_page, int_status, int_mask, pnum;
  logic [7:0] alloc_result, done_head, rx_head, mem_pages, used_pages;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  pkt_page_mmu #(.NUM_PAGES(4)) i_pkt_page_mmu (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
    .pnum_wr(pnum_wr), .pnum_in(pnum_in), .ack_wr(ack_wr), .ack_in(ack_in),
    .mask_wr(mask_wr), .mask_in(mask_in), .rx_req(rx_req), .tx_en(tx_en),
    .auto_rel(auto_rel), .rx_resp_vld(rx_resp_vld), .rx_resp_page(rx_resp_page),
    .tx_strobe(tx_strobe), .tx_page(tx_page), .irq(irq), .int_status(int_status),
    .int_mask(int_mask), .pnum(pnum), .alloc_result(alloc_result),
    .done_head(done_head), .rx_head(rx_head), .mem_pages(mem_pages),
    .used_pages(used_pages)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cmd_raw(input logic [7:0] b);
    cmd_wr = 1; cmd_byte = b; tick(); cmd_wr = 0;
  endtask

  task automatic cmd(input logic [2:0] c);
    cmd_raw({c, 5'b0});
  endtask

  task automatic setp(input logic [7:0] v);
    pnum_wr = 1; pnum_in = v; tick(); pnum_wr = 0;
  endtask

  task automatic ack(input logic [7:0] v);
    ack_wr = 1; ack_in = v; tick(); ack_wr = 0;
  endtask

  task automatic setm(input logic [7:0] v);
    mask_wr = 1; mask_in = v; tick(); mask_wr = 0;
  endtask

  task automatic rx();
    rx_req = 1; tick(); rx_req = 0;
  endtask

  task automatic rx_collide();
    rx_req = 1; cmd_wr = 1; cmd_byte = 8'h00; tick(); rx_req = 0; cmd_wr = 0;
  endtask

  task automatic txc(input logic a);
    tx_en = 1; auto_rel = a; tick(); tx_en = 0; auto_rel = 0;
  endtask

  task automatic do_reset();
    rst = 1; tick(); tick(); rst = 0;
  endtask

  // builds status 0x1F with one page (1) in the completion queue
  task automatic build_status();
    do_reset();
    rx();
    cmd(3'd1);
    setp(8'd1);
    cmd(3'd6);
    txc(1'b0);
    rx_collide();
  endtask

  initial begin
    tick();
    do_reset();
    // R1 reset state
    chk("R1 status", int_status, 8'h04);
    chk("R1 mask", int_mask, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'd0);
    chk("R1 result", alloc_result, 8'h80);
    chk("R1 used", used_pages, 8'd0);
    chk("R1 rx_head", rx_head, 8'h80);
    chk("R1 done_head", done_head, 8'h80);
    chk("R1 mem_pages", mem_pages, 8'd4);
    chk("R1 strobe", {7'b0, tx_strobe}, 8'd0);

    // R2 low bits ignored, code 0 no-op
    cmd_raw(8'h1F);
    chk("R2 result", alloc_result, 8'h80);
    chk("R2 used", used_pages, 8'd0);
    chk("R2 status", int_status, 8'h04);

    // R3 lowest-free sweep
    for (int p = 0; p < 4; p++) begin
      cmd(3'd1);
      chk("R3 result", alloc_result, 8'(p));
      chk("R3 used", used_pages, 8'(p + 1));
      chk("R3 alloc bit", {7'b0, int_status[3]}, 8'd1);
    end
    // R4 fail then retry on release
    cmd(3'd1);
    chk("R4 fail result", alloc_result, 8'h80);
    chk("R4 fail bit", {7'b0, int_status[3]}, 8'd0);
    setp(8'd2);
    cmd(3'd5);
    chk("R4 retry result", alloc_result, 8'd2);
    chk("R4 retry bit", {7'b0, int_status[3]}, 8'd1);
    chk("R4 retry used", used_pages, 8'd4);
    // R3 with holes, R11 release by pnum
    setp(8'd1); cmd(3'd5);
    chk("R11 release used", used_pages, 8'd3);
    chk("R3 no retry", alloc_result, 8'd2);
    setp(8'd3); cmd(3'd5);
    cmd(3'd1);
    chk("R3 hole pick", alloc_result, 8'd1);
    chk("R3 hole used", used_pages, 8'd3);

    // R12 allocator reset clears pending
    cmd(3'd1);
    cmd(3'd1);
    chk("R4 fail again", alloc_result, 8'h80);
    cmd(3'd2);
    chk("R12 used", used_pages, 8'd0);
    chk("R12 result", alloc_result, 8'h80);
    setp(8'd0); cmd(3'd5);
    chk("R12 pending gone", alloc_result, 8'h80);

    // R8 receive allocation
    for (int p = 0; p < 4; p++) begin
      rx();
      chk("R8 vld", {7'b0, rx_resp_vld}, 8'd1);
      chk("R8 page", rx_resp_page, 8'(p));
      chk("R13 rx_head", rx_head, 8'd0);
      chk("R8 rcv bit", {7'b0, int_status[0]}, 8'd1);
      chk("R13 used", used_pages, 8'(p + 1));
    end
    rx();
    chk("R8 full page", rx_resp_page, 8'h80);
    chk("R8 overrun", {7'b0, int_status[4]}, 8'd1);
    chk("R8 full used", used_pages, 8'd4);

    // R9 pops
    cmd(3'd3);
    chk("R9 pop head", rx_head, 8'd1);
    chk("R9 pop bit", {7'b0, int_status[0]}, 8'd1);
    chk("R9 pop used", used_pages, 8'd4);
    cmd(3'd4);
    chk("R9 poprel head", rx_head, 8'd2);
    chk("R9 poprel used", used_pages, 8'd3);
    cmd(3'd4);
    chk("R9 poprel2 used", used_pages, 8'd2);
    cmd(3'd3);
    chk("R9 empty head", rx_head, 8'h80);
    chk("R9 empty bit", {7'b0, int_status[0]}, 8'd0);
    chk("R9 last used", used_pages, 8'd2);
    cmd(3'd4);
    chk("R9 empty poprel", used_pages, 8'd2);

    // R8 collision refusal
    rx_collide();
    chk("R8 collide vld", {7'b0, rx_resp_vld}, 8'd1);
    chk("R8 collide page", rx_resp_page, 8'h80);
    chk("R8 collide used", used_pages, 8'd2);

    // R8 queue-full refusal with a free page
    cmd(3'd2);
    for (int p = 0; p < 4; p++) rx();
    setp(8'd0); cmd(3'd5);
    chk("R8 qfull setup", used_pages, 8'd3);
    rx();
    chk("R8 qfull page", rx_resp_page, 8'h80);
    chk("R8 qfull used", used_pages, 8'd3);

    // R10/R11 transmit queue
    cmd(3'd2);
    chk("R12 rxq cleared", rx_head, 8'h80);
    cmd(3'd1); cmd(3'd1); cmd(3'd1);
    setp(8'd2); cmd(3'd6);
    setp(8'd0); cmd(3'd6);
    setp(8'd1); cmd(3'd6);
    ack(8'h04);
    chk("R7 txe clears when busy", {7'b0, int_status[2]}, 8'd0);
    setp(8'd3); cmd(3'd6);
    setp(8'd0); cmd(3'd6);  // fifth push ignored (R11)
    txc(1'b0);
    chk("R10 strobe", {7'b0, tx_strobe}, 8'd1);
    chk("R10 page0", tx_page, 8'd2);
    txc(1'b0);
    chk("R10 page1", tx_page, 8'd0);
    txc(1'b0);
    chk("R10 page2", tx_page, 8'd1);
    txc(1'b0);
    chk("R10 page3", tx_page, 8'd3);
    txc(1'b0);
    chk("R11 full push dropped", {7'b0, tx_strobe}, 8'd0);
    chk("R7 txe set", {7'b0, int_status[2]}, 8'd1);
    chk("R7 tx set", {7'b0, int_status[1]}, 8'd1);
    chk("R13 done_head", done_head, 8'd2);
    chk("R10 used", used_pages, 8'd3);
    setp(8'd1); cmd(3'd6);
    txc(1'b0);
    chk("R10 fifth strobe", tx_page, 8'd1);
    ack(8'h02);
    chk("R6 pop1", done_head, 8'd0);
    ack(8'h02);
    chk("R6 pop2", done_head, 8'd1);
    ack(8'h02);
    chk("R6 pop3", done_head, 8'd3);
    ack(8'h02);
    chk("R10 done full drop", done_head, 8'h80);
    chk("R7 tx bit cleared", {7'b0, int_status[1]}, 8'd0);
    setp(8'd1); cmd(3'd6);
    txc(1'b1);
    chk("R10 auto strobe", tx_page, 8'd1);
    chk("R10 auto used", used_pages, 8'd2);
    chk("R10 auto no done", done_head, 8'h80);
    setp(8'd0); cmd(3'd6);
    cmd(3'd7);
    txc(1'b0);
    chk("R12 txclr", {7'b0, tx_strobe}, 8'd0);
    chk("R12 txclr used", used_pages, 8'd2);
    // R4 retry via auto-release
    cmd(3'd1); cmd(3'd1); cmd(3'd1);
    chk("R4 pending", alloc_result, 8'h80);
    setp(8'd3); cmd(3'd6);
    txc(1'b1);
    chk("R4 auto retry result", alloc_result, 8'd3);
    chk("R4 auto retry bit", {7'b0, int_status[3]}, 8'd1);
    chk("R4 auto retry used", used_pages, 8'd4);

    // R6/R7 acknowledge sweep
    build_status();
    chk("R6 setup", int_status, 8'h1F);
    for (int a = 0; a < 256; a++) begin
      build_status();
      ack(8'(a));
      chk("R6 ack status", int_status,
          (8'h1F & ~(8'(a) & 8'hD6)) | 8'h04);
      chk("R6 ack done pop", done_head, a[1] ? 8'h80 : 8'h01);
    end

    // R5 mask sweep
    build_status();
    for (int m = 0; m < 256; m++) begin
      setm(8'(m));
      chk("R5 irq", {7'b0, irq}, {7'b0, |(8'h1F & 8'(m))});
      chk("R5 mask", int_mask, 8'(m));
    end

    summary();
    $finish;
  end
endmodule